// File: doc/BRIEF.md
# Four-Bank GPIO Controller with Edge Interrupts

This block is a register-mapped general-purpose I/O controller for 128 pins, arranged as four banks of 32. Software reaches it over a plain single-cycle bus. A write is taken on the clock edge while `wr_en` is high. A read is combinational from `addr` to `rdata`. For each bank, software sets the pin direction and moves the output latch through separate set and clear registers. It reads the pin levels back, chooses which input edges are recorded, and clears recorded edges by writing ones. Two alternate-function words per bank are kept for software and affect nothing else.

The input pins pass through a two-flop synchronizer and then an edge detector. Recorded edges drive three interrupt lines: one for bank-0 pin 0, one for bank-0 pin 1, and one shared by every other pin. While the core reports itself halted, a level change on a wake-capable input pin raises a one-cycle wake request.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset every direction bit is 0 (input), and every output latch, edge enable, edge status bit and alternate-function word is 0. `pin_oe`, `pin_out`, the three interrupt lines and `wake_req` are all low.
- R2: Register offsets. Bank b (b=0..2) places level at 0x000+4b, direction at 0x00C+4b, output-set at 0x018+4b, output-clear at 0x024+4b, rising enable at 0x030+4b, falling enable at 0x03C+4b and edge status at 0x048+4b. Bank 3 uses the bank-0 offsets plus 0x100. The alternate-function low and high words of bank b sit at 0x054+8b and 0x058+8b.
- R3: An access at offset 0x200 or above, or at any offset not listed in R2, changes no state, and a read of it returns 0.
- R4: A level read returns, per bit, the output latch where the direction bit is 1 and the synchronized input where it is 0. An input change shows in the level read after two clock edges.
- R5: A write to output-set ORs the data into the bank's latch, and a write to output-clear clears every latch bit written as 1. `pin_oe` equals the direction bits, and `pin_out` is the latch ANDed with the direction bits.
- R6: Reading output-set returns the last value written there. Reading output-clear returns the constant 0x0BAD0C1E.
- R7: An edge-status bit is set by a synchronized 0-to-1 change when its rising enable is 1, or by a 1-to-0 change when its falling enable is 1. In both cases the pin's direction must be input. The bit becomes visible three clock edges after `pin_in` changes. A pin set as output never sets status.
- R8: Writing 1 to an edge-status bit clears it, and the bit otherwise holds. If a new edge and a clear hit the same bit in the same cycle, the bit ends up set.
- R9: `irq_pin0` follows bank-0 status bit 0, `irq_pin1` follows bank-0 status bit 1, and `irq_other` is the OR of all other status bits in all banks.
- R10: `wake_req` rises for one cycle, on the same edge at which status would be recorded, when `halted` is high and an input pin whose bit is set in the wake mask changes level. The wake masks for banks 0..3 are 0x8003FE1B, 0x002001FC, 0xEC080000 and 0x0012007F.
- R11: Alternate-function words read back as written and have no effect on `pin_out` or `pin_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | AW (12) | Register byte offset |
| wr_en | input | 1 | Write strobe, taken on the clock edge |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data |
| pin_in | input | 128 | Raw pin inputs |
| pin_out | output | 128 | Driven pin values |
| pin_oe | output | 128 | Pin output enables |
| halted | input | 1 | Core halted indication |
| irq_pin0 | output | 1 | Interrupt for bank-0 pin 0 |
| irq_pin1 | output | 1 | Interrupt for bank-0 pin 1 |
| irq_other | output | 1 | Interrupt for all other pins |
| wake_req | output | 1 | Wake request pulse |

## Verification
The bench builds the controller with its default parameters: a 12-bit offset, the stated clear-read constant and the stated wake masks. With these, the map has only 36 registers and 128 pins, so every register is read after reset. A rising and then a falling edge is walked through every one of the 128 pins, which makes each status bit, the interrupt grouping and every wake-mask bit observable one by one. Directed cases cover the scattered bank-3 offsets, out-of-range writes, pins set as outputs, and a clear colliding with a new edge.

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl #(
  parameter int          AW        = 12,
  parameter logic [31:0] CLR_READ  = 32'h0BAD_0C1E,
  parameter logic [127:0] WAKE_MASK = {32'h0012_007F, 32'hEC08_0000, 32'h0020_01FC, 32'h8003_FE1B}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  input  logic [127:0]  pin_in,
  output logic [127:0]  pin_out,
  output logic [127:0]  pin_oe,
  input  logic          halted,
  output logic          irq_pin0,
  output logic          irq_pin1,
  output logic          irq_other,
  output logic          wake_req
);
  localparam int NB = 4;
  localparam int BW = 32;
  localparam int NP = NB * BW;

  typedef enum logic [3:0] {K_NONE, K_LVL, K_DIR, K_SET, K_CLR, K_RISE, K_FALL, K_STAT, K_AFL, K_AFH} kind_t;

  kind_t       kind;
  logic [1:0]  bank;
  logic [31:0] a;
  logic [31:0] base;

  always_comb begin
    kind = K_NONE;
    bank = '0;
    a    = 32'(addr);
    base = '0;
    for (int b = 0; b < NB; b++) begin
      base = (b == NB - 1) ? 32'h100 : 32'(4 * b);
      if (a == base)                 begin kind = K_LVL;  bank = 2'(b); end
      if (a == base + 32'h00C)       begin kind = K_DIR;  bank = 2'(b); end
      if (a == base + 32'h018)       begin kind = K_SET;  bank = 2'(b); end
      if (a == base + 32'h024)       begin kind = K_CLR;  bank = 2'(b); end
      if (a == base + 32'h030)       begin kind = K_RISE; bank = 2'(b); end
      if (a == base + 32'h03C)       begin kind = K_FALL; bank = 2'(b); end
      if (a == base + 32'h048)       begin kind = K_STAT; bank = 2'(b); end
      if (a == 32'h054 + 32'(8 * b)) begin kind = K_AFL;  bank = 2'(b); end
      if (a == 32'h058 + 32'(8 * b)) begin kind = K_AFH;  bank = 2'(b); end
    end
  end

  logic [NP-1:0] dir_q, olat_q, rise_q, fall_q, stat_q;
  logic [NP-1:0] sync1_q, sync2_q, prev_q;
  logic [BW-1:0] setw_q [NB];
  logic [BW-1:0] afl_q  [NB];
  logic [BW-1:0] afh_q  [NB];

  logic [NP-1:0] wvec, bmask, stat_set, stat_clr, lvl;
  assign wvec     = {{(NP-BW){1'b0}}, wdata} << {bank, 5'b0};
  assign bmask    = {{(NP-BW){1'b0}}, {BW{1'b1}}} << {bank, 5'b0};
  assign stat_set = ((sync2_q & ~prev_q & rise_q) | (~sync2_q & prev_q & fall_q)) & ~dir_q;
  assign stat_clr = (wr_en && kind == K_STAT) ? wvec : '0;
  assign lvl      = (olat_q & dir_q) | (sync2_q & ~dir_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0; olat_q <= '0; rise_q <= '0; fall_q <= '0; stat_q <= '0;
      sync1_q <= '0; sync2_q <= '0; prev_q <= '0;
      wake_req <= 1'b0;
      for (int b = 0; b < NB; b++) begin
        setw_q[b] <= '0; afl_q[b] <= '0; afh_q[b] <= '0;
      end
    end else begin
      sync1_q  <= pin_in;
      sync2_q  <= sync1_q;
      prev_q   <= sync2_q;
      wake_req <= halted && |((sync2_q ^ prev_q) & ~dir_q & WAKE_MASK);
      stat_q   <= (stat_q & ~stat_clr) | stat_set;
      if (wr_en) begin
        case (kind)
          K_DIR:  dir_q  <= (dir_q & ~bmask) | wvec;
          K_SET:  begin olat_q <= olat_q | wvec; setw_q[bank] <= wdata; end
          K_CLR:  olat_q <= olat_q & ~wvec;
          K_RISE: rise_q <= (rise_q & ~bmask) | wvec;
          K_FALL: fall_q <= (fall_q & ~bmask) | wvec;
          K_AFL:  afl_q[bank] <= wdata;
          K_AFH:  afh_q[bank] <= wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (kind)
      K_LVL:   rdata = lvl[bank*BW +: BW];
      K_DIR:   rdata = dir_q[bank*BW +: BW];
      K_SET:   rdata = setw_q[bank];
      K_CLR:   rdata = CLR_READ;
      K_RISE:  rdata = rise_q[bank*BW +: BW];
      K_FALL:  rdata = fall_q[bank*BW +: BW];
      K_STAT:  rdata = stat_q[bank*BW +: BW];
      K_AFL:   rdata = afl_q[bank];
      K_AFH:   rdata = afh_q[bank];
      default: rdata = '0;
    endcase
  end

  assign pin_oe    = dir_q;
  assign pin_out   = olat_q & dir_q;
  assign irq_pin0  = stat_q[0];
  assign irq_pin1  = stat_q[1];
  assign irq_other = |stat_q[NP-1:2];

  // R3
  oob_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && a >= 32'h200) |=> ($stable(dir_q) && $stable(olat_q) && $stable(rise_q)));
  // R8
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && kind == K_STAT) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
  // R7
  out_no_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & ~$past(stat_q) & $past(dir_q)) == '0));
  // R5
  drive_only_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_out & ~pin_oe) == '0));
  // R10
  wake_halted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> $past(halted));
endmodule

// File: tb/gpio_bank_ctrl_tb.sv
module gpio_bank_ctrl_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [11:0]  addr = '0;
  logic         wr_en = 1'b0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic [127:0] pin_in = '0;
  logic [127:0] pin_out, pin_oe;
  logic         halted = 1'b0;
  logic         irq_pin0, irq_pin1, irq_other, wake_req;

  int nchk = 0;
  int nerr = 0;

  localparam logic [31:0]  CLRV = 32'h0BAD_0C1E;
  localparam logic [127:0] WM   = {32'h0012_007F, 32'hEC08_0000, 32'h0020_01FC, 32'h8003_FE1B};

  always #4 clk = ~clk;

  gpio_bank_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .halted(halted),
    .irq_pin0(irq_pin0), .irq_pin1(irq_pin1), .irq_other(irq_other), .wake_req(wake_req)
  );

  // k: 0 level, 1 dir, 2 set, 3 clr, 4 rise, 5 fall, 6 status, 7 alt low, 8 alt high
  function automatic logic [11:0] off(input int k, input int b);
    logic [11:0] base;
    base = (b == 3) ? 12'h100 : 12'(4 * b);
    case (k)
      0: return base;
      1: return base + 12'h00C;
      2: return base + 12'h018;
      3: return base + 12'h024;
      4: return base + 12'h030;
      5: return base + 12'h03C;
      6: return base + 12'h048;
      7: return 12'h054 + 12'(8 * b);
      default: return 12'h058 + 12'(8 * b);
    endcase
  endfunction

  task automatic chk(input logic [127:0] got, input logic [127:0] exp, input string tag);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rchk(input logic [11:0] a, input logic [31:0] exp, input string tag);
    addr = a;
    #1;
    chk(128'(rdata), 128'(exp), tag);
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [127:0] oe_s, out_s;
    wait_n(3);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state, R2 map, R6 clear constant
    for (int b = 0; b < 4; b++)
      for (int k = 0; k < 9; k++)
        rchk(off(k, b), (k == 3) ? CLRV : 32'h0, $sformatf("R1 reset k=%0d b=%0d", k, b));
    chk(pin_oe, '0, "R1 pin_oe");
    chk(pin_out, '0, "R1 pin_out");
    chk({irq_pin0, irq_pin1, irq_other, wake_req}, '0, "R1 irq/wake");

    // R4 R5 R6 per bank
    for (int b = 0; b < 4; b++) begin
      logic [31:0] d, s, c, lt, in;
      d  = 32'hF0F0_3C3C ^ (32'h1111_1111 * b);
      s  = 32'hA5A5_5A5A ^ (32'h0101_0101 * b);
      c  = 32'h0F00_00FF;
      lt = s & ~c;
      in = 32'h3333_CCCC ^ (32'h0F0F_0F0F * b);
      wr(off(1, b), d);
      wr(off(2, b), s);
      wr(off(3, b), c);
      chk(128'(pin_oe[b*32 +: 32]), 128'(d), "R5 pin_oe");
      chk(128'(pin_out[b*32 +: 32]), 128'(lt & d), "R5 pin_out");
      rchk(off(2, b), s, "R6 set readback");
      rchk(off(3, b), CLRV, "R6 clear readback");
      rchk(off(1, b), d, "R2 dir readback");
      pin_in[b*32 +: 32] = in;
      wait_n(2);
      rchk(off(0, b), (lt & d) | (in & ~d), "R4 level");
    end

    // R11 alternate-function words
    oe_s = pin_oe; out_s = pin_out;
    for (int b = 0; b < 4; b++) begin
      wr(off(7, b), 32'hC0DE_0000 | 32'(b));
      wr(off(8, b), 32'hFACE_0000 | 32'(b));
    end
    for (int b = 0; b < 4; b++) begin
      rchk(off(7, b), 32'hC0DE_0000 | 32'(b), "R11 alt low");
      rchk(off(8, b), 32'hFACE_0000 | 32'(b), "R11 alt high");
    end
    chk(pin_oe, oe_s, "R11 pin_oe untouched");
    chk(pin_out, out_s, "R11 pin_out untouched");

    // R3 out-of-range and unmapped
    rchk(12'h200, 32'h0, "R3 read 0x200");
    rchk(12'h0FC, 32'h0, "R3 read unmapped");
    wr(12'h200, 32'hFFFF_FFFF);
    wr(12'h30C, 32'hFFFF_FFFF);
    wr(12'h0FC, 32'hFFFF_FFFF);
    chk(pin_oe, oe_s, "R3 pin_oe unchanged");
    chk(pin_out, out_s, "R3 pin_out unchanged");
    rchk(off(1, 3), 32'hF0F0_3C3C ^ 32'h3333_3333, "R3 bank3 dir unchanged");

    // prepare edge sweep
    pin_in = '0;
    for (int b = 0; b < 4; b++) begin
      wr(off(1, b), 32'h0);
      wr(off(4, b), 32'hFFFF_FFFF);
      wr(off(5, b), 32'h5555_5555);
    end
    wait_n(4);
    for (int b = 0; b < 4; b++) begin
      wr(off(6, b), 32'hFFFF_FFFF);
      rchk(off(6, b), 32'h0, "R8 cleared before sweep");
    end
    halted = 1'b1;

    // R7 R8 R9 R10 walk every pin
    for (int p = 0; p < 128; p++) begin
      int b, bt;
      b = p / 32; bt = p % 32;
      @(negedge clk); pin_in[p] = 1'b1;
      wait_n(3);
      chk(128'(wake_req), 128'(WM[p]), $sformatf("R10 wake rise pin %0d", p));
      chk({irq_pin0, irq_pin1, irq_other}, {p == 0, p == 1, p >= 2}, $sformatf("R9 irq pin %0d", p));
      rchk(off(6, b), 32'(1) << bt, $sformatf("R7 rise pin %0d", p));
      wr(off(6, b), 32'(1) << bt);
      rchk(off(6, b), 32'h0, $sformatf("R8 w1c pin %0d", p));
      pin_in[p] = 1'b0;
      wait_n(3);
      chk(128'(wake_req), 128'(WM[p]), $sformatf("R10 wake fall pin %0d", p));
      rchk(off(6, b), (bt % 2 == 0) ? (32'(1) << bt) : 32'h0, $sformatf("R7 fall pin %0d", p));
      wr(off(6, b), 32'hFFFF_FFFF);
    end

    // R7 output pins record nothing
    wr(off(1, 0), 32'hFFFF_FFFF);
    @(negedge clk); pin_in[5] = 1'b1;
    wait_n(4);
    rchk(off(6, 0), 32'h0, "R7 output pin rise");
    chk(128'(irq_other), 128'(0), "R7 no irq for output pin");
    pin_in[5] = 1'b0;
    wait_n(4);
    rchk(off(6, 0), 32'h0, "R7 output pin fall");
    wr(off(1, 0), 32'h0);

    // R8 new edge wins over same-cycle clear
    @(negedge clk); pin_in[40] = 1'b1;
    wait_n(2);
    addr = off(6, 1); wdata = 32'hFFFF_FFFF; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    rchk(off(6, 1), 32'h0000_0100, "R8 set wins");
    wr(off(6, 1), 32'hFFFF_FFFF);

    // R10 no wake when not halted
    halted = 1'b0;
    @(negedge clk); pin_in[0] = 1'b1;
    wait_n(3);
    chk(128'(wake_req), 128'(0), "R10 not halted");
    chk(128'(irq_pin0), 128'(1), "R9 irq_pin0 while running");
    wr(off(6, 0), 32'h1);
    chk(128'(irq_pin0), 128'(0), "R9 irq_pin0 after clear");

    summary();
  end
endmodule